// File: doc/BRIEF.md
# GPIO and Control Register Block

This block is a small register file on a single-cycle memory-mapped bus. It holds six plain 16-bit storage registers (a mode word, a divider word, a clock-select word and three interrupt words that are kept as data only), a read-only status word, a power-control word with a write side effect, and a 16-line general-purpose I/O port. The port has a direction register and a level register. Each output pin carries the level bit gated by its direction bit.

The output pins are re-evaluated only when software writes the direction or the level register. On such a write, each pin whose gated value differs from the value it already drives is updated, and its change strobe pulses for one cycle. Sixteen input lines pass through a synchronizer. A transition on a synchronized line writes that line's bit of the level register. It does not touch the pins until the next direction or level write.

Top module: `gpreg_top`

## Requirements
- R1: Only address bits [5:0] are decoded. Any value of the upper address bits reaches the same register. Word offsets: 0x00 mode, 0x04 divider, 0x08 status, 0x0C power, 0x10 clock-select, 0x14 irq-raw, 0x18 irq-mask, 0x1C irq-flag, 0x20 direction, 0x24 and 0x28 level.
- R2: A write stores bits [15:0] of the bus write data and drops the upper bits. The six plain registers read back exactly what was stored.
- R3: A power write stores the value. When bit 7 of the value is 1, bits 15 and 6 are also set (OR with 0x8040).
- R4: The status register reads 0x0002, and writes to offset 0x08 have no effect.
- R5: A write to offset 0x24 or 0x28 stores the data ANDed with the current direction register. Both offsets read the level register.
- R6: Each output pin i equals level[i] AND direction[i]. The pins change only in the cycle after a direction or level write.
- R7: `gpio_chg[i]` is high for exactly the one cycle after an update in which pin i changed. Otherwise it is 0.
- R8: Each input line passes through a two-flop synchronizer. A transition of the synchronized line sets level[i] to the new line value three clock edges after the input changes. This does not change the pins. When a transition and a level write meet in the same cycle, the transition wins for that bit.
- R9: Reads of an unmapped offset (anything not listed in R1, including offsets with bits [1:0] not zero) return 0. Writes to one change nothing.
- R10: Read data is registered. A read presented at a clock edge shows its data after that edge. If a write happens in the same cycle, the read returns the value from before the write. `bus_rdata` holds its value when no read is issued.
- R11: After reset, every register except status is 0, all pins and strobes are 0, and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address; only bits [5:0] decoded |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data; bits [15:0] used |
| bus_rdata | output | 16 | Registered read data |
| gpio_in | input | 16 | Asynchronous input lines that update level bits |
| gpio_out | output | 16 | Output pins, level AND direction |
| gpio_chg | output | 16 | One-cycle per-pin change strobes |

## Verification
The bench drives directed writes whose data has the upper bus bits set and whose address has random upper bits. These show that truncation and the 6-bit decode each act. Direction and level writes come in patterns that grow, shrink and clear the pin set. Input transitions are applied with the bus idle, so that a pin that moves without a write stands apart from one that is correctly held. One directed case makes a synchronized transition and a level write land in the same cycle, which shows which source wins. A seeded random mix of mapped and unmapped reads and writes and input changes is checked against a bench model. That model keeps the level, direction and previous-pin state in its own form.

// File: rtl/gpreg_pkg.sv
package gpreg_pkg;

  localparam int REG_W      = 16;
  localparam int OFF_W      = 6;
  localparam int PLAIN_N    = 6;
  localparam logic [REG_W-1:0] PWR_FORCE = 16'h8040;
  localparam int PWR_TRIG_BIT = 7;

  localparam logic [OFF_W-1:0] OFF_MODE     = 6'h00;
  localparam logic [OFF_W-1:0] OFF_DIVIDE   = 6'h04;
  localparam logic [OFF_W-1:0] OFF_STATUS   = 6'h08;
  localparam logic [OFF_W-1:0] OFF_POWER    = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_CLKSEL   = 6'h10;
  localparam logic [OFF_W-1:0] OFF_IRQ_RAW  = 6'h14;
  localparam logic [OFF_W-1:0] OFF_IRQ_MASK = 6'h18;
  localparam logic [OFF_W-1:0] OFF_IRQ_FLAG = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_DIR      = 6'h20;
  localparam logic [OFF_W-1:0] OFF_LVL_A    = 6'h24;
  localparam logic [OFF_W-1:0] OFF_LVL_B    = 6'h28;

  // Plain storage registers take the codes 0..PLAIN_N-1 so the code is the slot.
  typedef enum logic [3:0] {
    SEL_MODE     = 4'd0,
    SEL_DIVIDE   = 4'd1,
    SEL_CLKSEL   = 4'd2,
    SEL_IRQ_RAW  = 4'd3,
    SEL_IRQ_MASK = 4'd4,
    SEL_IRQ_FLAG = 4'd5,
    SEL_STATUS   = 4'd6,
    SEL_POWER    = 4'd7,
    SEL_DIR      = 4'd8,
    SEL_LEVEL    = 4'd9,
    SEL_NONE     = 4'd15
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [OFF_W-1:0] off);
    reg_sel_e s;
    case (off)
      OFF_MODE:     s = SEL_MODE;
      OFF_DIVIDE:   s = SEL_DIVIDE;
      OFF_STATUS:   s = SEL_STATUS;
      OFF_POWER:    s = SEL_POWER;
      OFF_CLKSEL:   s = SEL_CLKSEL;
      OFF_IRQ_RAW:  s = SEL_IRQ_RAW;
      OFF_IRQ_MASK: s = SEL_IRQ_MASK;
      OFF_IRQ_FLAG: s = SEL_IRQ_FLAG;
      OFF_DIR:      s = SEL_DIR;
      OFF_LVL_A,
      OFF_LVL_B:    s = SEL_LEVEL;
      default:      s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Power write side effect: trigger bit forces the extra bits on.
  function automatic logic [REG_W-1:0] power_fold(input logic [REG_W-1:0] v);
    return v[PWR_TRIG_BIT] ? (v | PWR_FORCE) : v;
  endfunction

endpackage

// File: rtl/gpreg_decode.sv
module gpreg_decode
  import gpreg_pkg::*;
#(
  parameter int BUS_ADDR_W = 12
) (
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  output reg_sel_e              sel
);

  localparam int HI_W = BUS_ADDR_W - OFF_W;

  logic [OFF_W-1:0] offset;
  assign offset = bus_addr[OFF_W-1:0];
  assign sel    = decode_offset(offset);

  generate
    if (HI_W > 0) begin : g_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^bus_addr[BUS_ADDR_W-1:OFF_W];
    end
  endgenerate

endmodule

// File: rtl/gpreg_ctrl_file.sv
module gpreg_ctrl_file
  import gpreg_pkg::*;
#(
  parameter logic [REG_W-1:0] STATUS_RST = 16'h0002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] power_val
);

  logic [REG_W-1:0] plain_q [PLAIN_N];
  logic [REG_W-1:0] power_q;
  logic [3:0]       sel_code;

  assign sel_code  = sel;
  assign power_val = power_q;

  // Plain storage: no side effects, interrupt words included.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PLAIN_N; i++) plain_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < PLAIN_N; i++) begin
        if (sel_code == 4'(i)) plain_q[i] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          power_q <= '0;
    else if (wr_en && sel == SEL_POWER)  power_q <= power_fold(wdata);
  end

  // Status has no write path; it always returns its reset value.
  always_comb begin
    rdata = '0;
    case (sel)
      SEL_STATUS: rdata = STATUS_RST;
      SEL_POWER:  rdata = power_q;
      default: begin
        for (int i = 0; i < PLAIN_N; i++) begin
          if (sel_code == 4'(i)) rdata = plain_q[i];
        end
      end
    endcase
  end

endmodule

// File: rtl/gpreg_in_sync.sv
module gpreg_in_sync #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] sync_val,
  output logic [N-1:0] edge_mask
);

  localparam int LAST = STAGES - 1;

  logic [N-1:0] chain_q [STAGES];
  logic [N-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
      last_q <= '0;
    end else begin
      chain_q[0] <= din;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      last_q <= chain_q[LAST];
    end
  end

  assign sync_val  = chain_q[LAST];
  assign edge_mask = chain_q[LAST] ^ last_q;

endmodule

// File: rtl/gpreg_gpio_port.sv
module gpreg_gpio_port #(
  parameter int GPIO_N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_dir,
  input  logic              wr_lvl,
  input  logic [GPIO_N-1:0] wdata,
  input  logic [GPIO_N-1:0] edge_mask,
  input  logic [GPIO_N-1:0] edge_val,
  output logic [GPIO_N-1:0] dir_q,
  output logic [GPIO_N-1:0] lvl_q,
  output logic [GPIO_N-1:0] pin_q,
  output logic [GPIO_N-1:0] chg_q,
  output logic [GPIO_N-1:0] eff_next,
  output logic              upd_fire
);

  function automatic logic [GPIO_N-1:0] gate_drive(input logic [GPIO_N-1:0] lvl,
                                                   input logic [GPIO_N-1:0] dir);
    return lvl & dir;
  endfunction

  function automatic logic [GPIO_N-1:0] merge_edges(input logic [GPIO_N-1:0] base,
                                                    input logic [GPIO_N-1:0] mask,
                                                    input logic [GPIO_N-1:0] val);
    return (base & ~mask) | (val & mask);
  endfunction

  logic [GPIO_N-1:0] dir_n;
  logic [GPIO_N-1:0] lvl_base;
  logic [GPIO_N-1:0] lvl_n;

  assign dir_n    = wr_dir ? wdata : dir_q;
  assign lvl_base = wr_lvl ? gate_drive(wdata, dir_q) : lvl_q;
  assign lvl_n    = merge_edges(lvl_base, edge_mask, edge_val);
  assign eff_next = gate_drive(lvl_n, dir_n);
  assign upd_fire = wr_dir | wr_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else begin
      dir_q <= dir_n;
      lvl_q <= lvl_n;
    end
  end

  // Per-pin compare against the previously driven value.
  generate
    for (genvar i = 0; i < GPIO_N; i++) begin : g_pin
      logic differs;
      assign differs = upd_fire && (eff_next[i] != pin_q[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pin_q[i] <= 1'b0;
          chg_q[i] <= 1'b0;
        end else begin
          chg_q[i] <= differs;
          if (differs) pin_q[i] <= eff_next[i];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/gpreg_top.sv
module gpreg_top
  import gpreg_pkg::*;
#(
  parameter int BUS_ADDR_W = 12,
  parameter int BUS_DATA_W = 32,
  parameter int GPIO_N     = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] STATUS_RST = 16'h0002
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [BUS_DATA_W-1:0] bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  input  logic [GPIO_N-1:0]     gpio_in,
  output logic [GPIO_N-1:0]     gpio_out,
  output logic [GPIO_N-1:0]     gpio_chg
);

  reg_sel_e          sel;
  logic [3:0]        sel_code;
  logic [REG_W-1:0]  wdata16;
  logic [REG_W-1:0]  ctrl_rdata;
  logic [REG_W-1:0]  power_val;
  logic [REG_W-1:0]  rd_mux;
  logic [REG_W-1:0]  rdata_q;
  logic              wr_dir;
  logic              wr_lvl;
  logic [GPIO_N-1:0] in_sync;
  logic [GPIO_N-1:0] in_edge;
  logic [GPIO_N-1:0] dir_q;
  logic [GPIO_N-1:0] lvl_q;
  logic [GPIO_N-1:0] eff_next;
  logic              upd_fire;

  assign wdata16  = bus_wdata[REG_W-1:0];
  assign sel_code = sel;
  assign wr_dir   = bus_wr && (sel == SEL_DIR);
  assign wr_lvl   = bus_wr && (sel == SEL_LEVEL);

  generate
    if (BUS_DATA_W > REG_W) begin : g_wide
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[BUS_DATA_W-1:REG_W];
    end
  endgenerate

  gpreg_decode #(.BUS_ADDR_W(BUS_ADDR_W)) u_decode (
    .bus_addr (bus_addr),
    .sel      (sel)
  );

  gpreg_ctrl_file #(.STATUS_RST(STATUS_RST)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .sel       (sel),
    .wdata     (wdata16),
    .rdata     (ctrl_rdata),
    .power_val (power_val)
  );

  gpreg_in_sync #(.N(GPIO_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (gpio_in),
    .sync_val  (in_sync),
    .edge_mask (in_edge)
  );

  gpreg_gpio_port #(.GPIO_N(GPIO_N)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_dir    (wr_dir),
    .wr_lvl    (wr_lvl),
    .wdata     (wdata16[GPIO_N-1:0]),
    .edge_mask (in_edge),
    .edge_val  (in_sync),
    .dir_q     (dir_q),
    .lvl_q     (lvl_q),
    .pin_q     (gpio_out),
    .chg_q     (gpio_chg),
    .eff_next  (eff_next),
    .upd_fire  (upd_fire)
  );

  always_comb begin
    case (sel)
      SEL_DIR:   rd_mux = REG_W'(dir_q);
      SEL_LEVEL: rd_mux = REG_W'(lvl_q);
      SEL_NONE:  rd_mux = '0;
      default:   rd_mux = ctrl_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/gpreg_checker.sv
module gpreg_checker
  import gpreg_pkg::*;
#(
  parameter int GPIO_N = 16,
  parameter logic [REG_W-1:0] STATUS_RST = 16'h0002
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [REG_W-1:0]  wdata16,
  input logic [3:0]        sel_code,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [REG_W-1:0]  power_val,
  input logic [GPIO_N-1:0] gpio_out,
  input logic [GPIO_N-1:0] gpio_chg,
  input logic [GPIO_N-1:0] dir_q,
  input logic [GPIO_N-1:0] lvl_q,
  input logic [GPIO_N-1:0] in_edge,
  input logic [GPIO_N-1:0] in_sync,
  input logic              upd_fire
);

  assert_power_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_code == 4'(SEL_POWER) && wdata16[PWR_TRIG_BIT])
      |=> (power_val[15] && power_val[6]));

  assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_code == 4'(SEL_STATUS)) |=> (bus_rdata == STATUS_RST));

  assert_level_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_code == 4'(SEL_LEVEL) && in_edge == '0)
      |=> ((lvl_q & ~$past(dir_q)) == '0));

  assert_out_within_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_out & ~dir_q) == '0);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> $stable(gpio_out));

  assert_strobe_diff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> (gpio_chg == (gpio_out ^ $past(gpio_out))));

  assert_strobe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> (gpio_chg == '0));

  assert_edge_sets_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_edge != '0) |=> (((lvl_q ^ $past(in_sync)) & $past(in_edge)) == '0));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_code == 4'(SEL_NONE)) |=> (bus_rdata == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpreg_top gpreg_checker #(.GPIO_N(GPIO_N), .STATUS_RST(STATUS_RST)) u_gpreg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .wdata16   (wdata16),
  .sel_code  (sel_code),
  .bus_rdata (bus_rdata),
  .power_val (power_val),
  .gpio_out  (gpio_out),
  .gpio_chg  (gpio_chg),
  .dir_q     (dir_q),
  .lvl_q     (lvl_q),
  .in_edge   (in_edge),
  .in_sync   (in_sync),
  .upd_fire  (upd_fire)
);

// File: tb/gpreg_top_bench.sv
`timescale 1ns/1ps
module gpreg_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] gpio_in = '0;
  logic [15:0] gpio_out;
  logic [15:0] gpio_chg;

  always #10 clk = ~clk;   // 50 MHz

  gpreg_top u_gpreg_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_chg(gpio_chg)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Bench model, kept by word slot (offset >> 2).
  logic [15:0] m_store [0:10];
  logic [15:0] m_pwr, m_dir, m_lvl, m_out, m_stb, m_in;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit b_mapped(input logic [5:0] off);
    return (off[1:0] == 2'b00) && (off <= 6'h28);
  endfunction

  function automatic string b_req(input logic [5:0] off);
    if (!b_mapped(off)) return "R9";
    case (off[5:2])
      4'd2: return "R4";
      4'd3: return "R3";
      4'd8, 4'd9, 4'd10: return "R5";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [15:0] b_read(input logic [5:0] off);
    if (!b_mapped(off)) return 16'h0000;
    case (off[5:2])
      4'd2: return 16'h0002;
      4'd3: return m_pwr;
      4'd8: return m_dir;
      4'd9, 4'd10: return m_lvl;
      default: return m_store[off[5:2]];
    endcase
  endfunction

  task automatic b_write(input logic [5:0] off, input logic [15:0] d);
    logic [15:0] nxt;
    m_stb = '0;
    if (!b_mapped(off)) return;
    case (off[5:2])
      4'd2: ;
      4'd3: m_pwr = d[7] ? (d | 16'h8040) : d;
      4'd8, 4'd9, 4'd10: begin
        if (off[5:2] == 4'd8) m_dir = d;
        else                  m_lvl = d & m_dir;
        nxt   = m_lvl & m_dir;
        m_stb = nxt ^ m_out;
        m_out = nxt;
      end
      default: m_store[off[5:2]] = d;
    endcase
  endtask

  task automatic do_write(input logic [5:0] off, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = {6'($urandom), off};
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    b_write(off, d[15:0]);
    chk("R6", "pins after write", gpio_out, m_out);
    chk("R7", "strobe after write", gpio_chg, m_stb);
  endtask

  task automatic do_read(input logic [5:0] off);
    @(negedge clk);
    bus_addr = {6'($urandom), off};
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(b_req(off), $sformatf("read off %h", off), bus_rdata, b_read(off));
  endtask

  task automatic set_inputs(input logic [15:0] v);
    logic [15:0] moved;
    @(negedge clk);
    gpio_in = v;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8", "pins held during input change", gpio_out, m_out);
      chk("R8", "no strobe on input change", gpio_chg, 16'h0000);
    end
    moved = v ^ m_in;
    m_lvl = (m_lvl & ~moved) | (v & moved);
    m_in  = v;
  endtask

  logic [15:0] held;

  initial begin
    void'($urandom(32'h1D2C3B4A));
    for (int s = 0; s <= 10; s++) m_store[s] = '0;
    m_pwr = '0; m_dir = '0; m_lvl = '0; m_out = '0; m_stb = '0; m_in = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk("R11", "rdata after reset", bus_rdata, 16'h0000);
    chk("R11", "pins after reset", gpio_out, 16'h0000);
    chk("R11", "strobes after reset", gpio_chg, 16'h0000);
    for (int o = 0; o <= 6'h28; o += 4) do_read(6'(o));

    // R2 / R1: truncation and aliasing by upper address bits
    do_write(6'h00, 32'hDEAD_1234);
    do_read(6'h00);
    do_write(6'h1C, 32'hFFFF_A5A5);
    do_read(6'h1C);
    do_write(6'h14, 32'h0001_0F0F);
    do_read(6'h14);
    chk("R1", "read via other upper bits", b_read(6'h14), 16'h0F0F);

    // R3: power side effect, with and without trigger bit
    do_write(6'h0C, 32'h0000_0081);
    do_read(6'h0C);
    chk("R3", "power forced bits", m_pwr, 16'h80C1);
    do_write(6'h0C, 32'h0000_0102);
    do_read(6'h0C);

    // R4: status ignores writes
    do_write(6'h08, 32'h0000_FFFF);
    do_read(6'h08);

    // R5 / R6 / R7: direction and level
    do_write(6'h24, 32'h0000_FFFF);    // dir is 0, so nothing stored
    do_read(6'h28);
    do_write(6'h20, 32'h0000_00FF);
    do_write(6'h28, 32'h0000_F0F0);    // stored 0x00F0, pins 0x00F0
    do_read(6'h24);
    do_write(6'h20, 32'h0000_0F0F);    // pins shrink to 0x0000
    do_write(6'h20, 32'h0000_FFFF);    // pins back to 0x00F0
    do_write(6'h24, 32'h0000_0000);    // all pins clear

    // R9: unmapped reads and writes
    do_write(6'h2C, 32'h0000_5555);
    do_write(6'h02, 32'h0000_5555);
    do_read(6'h2C);
    do_read(6'h3C);
    do_read(6'h01);
    for (int o = 0; o <= 6'h28; o += 4) do_read(6'(o));

    // R8: input transitions reach level but not the pins
    set_inputs(16'h0300);
    do_read(6'h24);
    do_write(6'h20, 32'h0000_0100);    // pins re-evaluate: 0x0100
    chk("R8", "pin after dir write following input", gpio_out, 16'h0100);

    // R8: transition and level write land in the same cycle; transition wins
    do_write(6'h20, 32'h0000_00FF);
    @(negedge clk);
    gpio_in = m_in | 16'h0008;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    bus_addr = 12'h024; bus_wdata = 32'h0000_00F0; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    b_write(6'h24, 16'h00F0);
    m_lvl = m_lvl | 16'h0008;
    m_in  = gpio_in;
    m_stb = (m_lvl & m_dir) ^ m_out;
    m_out = m_lvl & m_dir;
    chk("R8", "edge wins over write", gpio_out, 16'h00F8);
    do_read(6'h28);

    // R10: read and write in the same cycle return the old value, then hold
    @(negedge clk);
    bus_addr = 12'h000; bus_wdata = 32'h0000_7777; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R10", "read beside write sees old value", bus_rdata, m_store[0]);
    b_write(6'h00, 16'h7777);
    held = bus_rdata;
    repeat (3) @(negedge clk);
    chk("R10", "rdata holds without read", bus_rdata, held);
    do_read(6'h00);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      int pick;
      logic [5:0] off;
      op   = $urandom % 8;
      pick = $urandom % 14;
      off  = (pick < 11) ? 6'(pick * 4) : 6'($urandom);
      if (op < 4)      do_write(off, $urandom);
      else if (op < 7) do_read(off);
      else             set_inputs(16'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end

endmodule